// File: doc/BRIEF.md
# Display PHY Power Sequencer

This block drives the power, reset and lane-enable control bits of a serial display PHY. A one-cycle power-up request starts a fixed bring-up order: the bandgap is powered, power-good is asserted with its bypass released, the PLL and LDO are powered, and the clock lane and data lanes are enabled. Then come an active-high analog reset pulse, an active-low digital reset pulse and a one-cycle timing-load strobe. After a final settle wait, `done` is raised. A power-down request undoes the bring-up in reverse order in four cycles and also raises `done`.

The settle waits stand in for roughly one microsecond each. They come from one shared cycle counter whose length is computed at elaboration from the clock frequency and the wanted wait in nanoseconds. The number of data lanes is a configuration input. It is captured when a power-up request is accepted and drives a thermometer code on the lane-enable bits. The control outputs are laid out as two words: an 8-bit lane control word and a 3-bit power control word. Two single bits carry the digital reset and the second (LVDS) bandgap.

Top module: `dphy_pwr_seq`

## Requirements
- R1: While reset is held, and afterwards until a request is accepted, the lane control word is 0x82 (bandgap power-down and power-good bypass set), the power control word is 3'b011 (PLL and LDO powered down, analog reset low), `dig_rst_n` is 1, `lvds_bgpd`, `timing_load` and `done` are 0.
- R2: A power-up request is accepted at the first clock edge at which it is seen while idle, and `done` clears at that edge. The next four edges each change one thing, in this order: clear lane bit 7 (bandgap power-down); set bits 1..0 to 01 (power-good on, bypass off); clear power bits 1..0 (LDO and PLL power-down); write the lane enables.
- R3: The edge after the lane enables are written sets power bit 2 (analog reset, active high) for exactly SETTLE cycles. One cycle after it clears, `dig_rst_n` (active low) goes low for exactly SETTLE cycles.
- R4: One cycle after `dig_rst_n` returns high, `timing_load` is high for one cycle. `done` rises SETTLE cycles after `timing_load` rises.
- R5: Lane word bit 6 is the clock lane enable and bits 5..2 enable data lanes 3..0. Power-up with lane count N (1 to 4) sets bit 6 and data lanes 0 to N-1, and clears the other data lanes.
- R6: A lane count of 0 or greater than 4 enables the clock lane and data lane 0 only.
- R7: The lane count is captured when the power-up request is accepted. Later changes of the input do not alter the lanes written in that sequence.
- R8: A power-down request, accepted while idle, clears `done` at the accepting edge. On the four following edges it then clears lane bits 6..2, sets power bits 1..0, sets bits 1..0 of the lane word to 10, and finally sets lane bit 7 and `lvds_bgpd` together with `done`. Power-down never touches the analog or digital reset.
- R9: Requests that arrive while a sequence runs are ignored. A power-up and a power-down request seen together while idle start a power-up.
- R10: SETTLE equals SETTLE_NS x CLK_FREQ_KHZ / 1,000,000, rounded up, and is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_up_req | input | 1 | Request to run the power-up order |
| pwr_dn_req | input | 1 | Request to run the power-down order |
| lane_cnt | input | 3 | Number of data lanes to enable (1 to 4) |
| lane_ctrl | output | 8 | Lane control word: bandgap power-down, clock and data lane enables, power-good bypass, power-good |
| pwr_ctrl | output | 3 | Power control word: analog reset, LDO power-down, PLL power-down |
| dig_rst_n | output | 1 | Digital reset, active low |
| lvds_bgpd | output | 1 | Power-down of the second bandgap |
| timing_load | output | 1 | One-cycle strobe to load lane timing |
| done | output | 1 | Last sequence finished |

## Verification
The bench builds the block with four data lanes, a 4500 kHz clock setting and a 1000 ns wait. That gives a settle length of 4.5 cycles, rounded up to 5. This exercises the rounding in R10 and keeps each power-up near 25 cycles, short enough to compare every output bit on every cycle. Lane counts 0 to 7 cover the thermometer code and the values out of range. Requests and lane-count changes injected in the middle of a sequence show that a running sequence is never disturbed.

// File: rtl/dphy_pwr_pkg.sv
package dphy_pwr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UP_BG,
    ST_UP_PG,
    ST_UP_PLL,
    ST_UP_LANE,
    ST_UP_ARST,
    ST_UP_ARST_W,
    ST_UP_DRST,
    ST_UP_DRST_W,
    ST_UP_TLOAD,
    ST_UP_FIN_W,
    ST_DN_LANE,
    ST_DN_PLL,
    ST_DN_PG,
    ST_DN_BG
  } seq_state_e;

  // Power control word bit positions
  localparam int unsigned PWR_PLL_PD = 0;
  localparam int unsigned PWR_LDO_PD = 1;
  localparam int unsigned PWR_ARST   = 2;

  // Lane word low bits
  localparam int unsigned LW_PG      = 0;
  localparam int unsigned LW_PG_BYP  = 1;
  localparam int unsigned LW_DATA_LO = 2;

  // Settle length in cycles, rounded up, never below one
  function automatic int unsigned settle_cycles(input int unsigned ns,
                                                input int unsigned khz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(ns) * longint'(khz);
    cyc  = (prod + 64'd999_999) / 64'd1_000_000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/dphy_lane_decode.sv
module dphy_lane_decode #(
  parameter int unsigned DATA_LANES = 4,
  localparam int unsigned CNT_W = $clog2(DATA_LANES + 1)
) (
  input  logic [CNT_W-1:0]      lane_cnt,
  output logic [DATA_LANES-1:0] data_en
);

  logic [CNT_W-1:0] eff_cnt;

  always_comb begin
    if (lane_cnt == '0 || lane_cnt > CNT_W'(DATA_LANES)) eff_cnt = CNT_W'(1);
    else                                                 eff_cnt = lane_cnt;
  end

  for (genvar i = 0; i < DATA_LANES; i++) begin : g_lane
    assign data_en[i] = (eff_cnt > CNT_W'(i));
  end

endmodule

// File: rtl/dphy_settle_timer.sv
module dphy_settle_timer #(
  parameter int unsigned SETTLE_CYC = 50,
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    if (start) cnt_d = LOAD;
    else       cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dphy_seq_fsm.sv
module dphy_seq_fsm
  import dphy_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_req,
  input  logic       dn_req,
  input  logic       tmr_expired,
  output seq_state_e state,
  output logic       tmr_start
);

  seq_state_e nxt;

  always_comb begin
    nxt       = state;
    tmr_start = 1'b0;
    case (state)
      ST_IDLE: begin
        if (up_req)      nxt = ST_UP_BG;
        else if (dn_req) nxt = ST_DN_LANE;
      end
      ST_UP_BG:     nxt = ST_UP_PG;
      ST_UP_PG:     nxt = ST_UP_PLL;
      ST_UP_PLL:    nxt = ST_UP_LANE;
      ST_UP_LANE:   nxt = ST_UP_ARST;
      ST_UP_ARST: begin
        tmr_start = 1'b1;
        nxt       = ST_UP_ARST_W;
      end
      ST_UP_ARST_W: if (tmr_expired) nxt = ST_UP_DRST;
      ST_UP_DRST: begin
        tmr_start = 1'b1;
        nxt       = ST_UP_DRST_W;
      end
      ST_UP_DRST_W: if (tmr_expired) nxt = ST_UP_TLOAD;
      ST_UP_TLOAD: begin
        tmr_start = 1'b1;
        nxt       = ST_UP_FIN_W;
      end
      ST_UP_FIN_W:  if (tmr_expired) nxt = ST_IDLE;
      ST_DN_LANE:   nxt = ST_DN_PLL;
      ST_DN_PLL:    nxt = ST_DN_PG;
      ST_DN_PG:     nxt = ST_DN_BG;
      ST_DN_BG:     nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/dphy_pwr_seq.sv
module dphy_pwr_seq
  import dphy_pwr_pkg::*;
#(
  parameter int unsigned DATA_LANES   = 4,
  parameter int unsigned CLK_FREQ_KHZ = 50_000,
  parameter int unsigned SETTLE_NS    = 1000,
  localparam int unsigned CNT_W = $clog2(DATA_LANES + 1),
  localparam int unsigned LW    = DATA_LANES + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_up_req,
  input  logic             pwr_dn_req,
  input  logic [CNT_W-1:0] lane_cnt,
  output logic [LW-1:0]    lane_ctrl,
  output logic [2:0]       pwr_ctrl,
  output logic             dig_rst_n,
  output logic             lvds_bgpd,
  output logic             timing_load,
  output logic             done
);

  localparam int unsigned SETTLE_CYC = settle_cycles(SETTLE_NS, CLK_FREQ_KHZ);
  localparam int unsigned BIT_BG     = LW - 1;
  localparam int unsigned BIT_CLK    = LW - 2;
  localparam int unsigned DATA_HI    = LW - 3;
  localparam logic [LW-1:0] LANE_RST = (LW'(1) << BIT_BG) | (LW'(1) << LW_PG_BYP);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  seq_state_e             state;
  logic                   tmr_start;
  logic                   tmr_expired;
  logic [DATA_LANES-1:0]  lane_dec;

  dphy_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .up_req      (pwr_up_req),
    .dn_req      (pwr_dn_req),
    .tmr_expired (tmr_expired),
    .state       (state),
    .tmr_start   (tmr_start)
  );

  dphy_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start   (tmr_start),
    .expired (tmr_expired)
  );

  dphy_lane_decode #(.DATA_LANES(DATA_LANES)) u_dec (
    .lane_cnt (lane_cnt),
    .data_en  (lane_dec)
  );

  // Output register next values
  logic [LW-1:0]         lane_q, lane_d;
  logic [2:0]            pwr_q, pwr_d;
  logic                  drn_q, drn_d;
  logic                  lvds_q, lvds_d;
  logic                  tl_q, tl_d;
  logic                  done_q, done_d;
  logic [DATA_LANES-1:0] lanes_q, lanes_d;
  logic                  upd_en;

  always_comb begin
    lane_d  = lane_q;
    pwr_d   = pwr_q;
    drn_d   = drn_q;
    lvds_d  = lvds_q;
    tl_d    = 1'b0;
    done_d  = done_q;
    lanes_d = lanes_q;
    upd_en  = (state != ST_IDLE) || pwr_up_req || pwr_dn_req;
    case (state)
      ST_IDLE: begin
        if (pwr_up_req) begin
          done_d  = 1'b0;
          lanes_d = lane_dec;
        end else if (pwr_dn_req) begin
          done_d  = 1'b0;
        end
      end
      ST_UP_BG:  lane_d[BIT_BG] = 1'b0;
      ST_UP_PG: begin
        lane_d[LW_PG_BYP] = 1'b0;
        lane_d[LW_PG]     = 1'b1;
      end
      ST_UP_PLL: begin
        pwr_d[PWR_PLL_PD] = 1'b0;
        pwr_d[PWR_LDO_PD] = 1'b0;
      end
      ST_UP_LANE: begin
        lane_d[BIT_CLK]            = 1'b1;
        lane_d[DATA_HI:LW_DATA_LO] = lanes_q;
      end
      ST_UP_ARST:   pwr_d[PWR_ARST] = 1'b1;
      ST_UP_ARST_W: if (tmr_expired) pwr_d[PWR_ARST] = 1'b0;
      ST_UP_DRST:   drn_d = 1'b0;
      ST_UP_DRST_W: if (tmr_expired) drn_d = 1'b1;
      ST_UP_TLOAD:  tl_d = 1'b1;
      ST_UP_FIN_W:  if (tmr_expired) done_d = 1'b1;
      ST_DN_LANE: begin
        lane_d[BIT_CLK]            = 1'b0;
        lane_d[DATA_HI:LW_DATA_LO] = '0;
      end
      ST_DN_PLL: begin
        pwr_d[PWR_PLL_PD] = 1'b1;
        pwr_d[PWR_LDO_PD] = 1'b1;
      end
      ST_DN_PG: begin
        lane_d[LW_PG_BYP] = 1'b1;
        lane_d[LW_PG]     = 1'b0;
      end
      ST_DN_BG: begin
        lane_d[BIT_BG] = 1'b1;
        lvds_d         = 1'b1;
        done_d         = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      lane_q  <= LANE_RST;
      pwr_q   <= 3'b011;
      drn_q   <= 1'b1;
      lvds_q  <= 1'b0;
      tl_q    <= 1'b0;
      done_q  <= 1'b0;
      lanes_q <= '0;
    end else if (upd_en) begin
      lane_q  <= lane_d;
      pwr_q   <= pwr_d;
      drn_q   <= drn_d;
      lvds_q  <= lvds_d;
      tl_q    <= tl_d;
      done_q  <= done_d;
      lanes_q <= lanes_d;
    end
  end

  assign lane_ctrl   = lane_q;
  assign pwr_ctrl    = pwr_q;
  assign dig_rst_n   = drn_q;
  assign lvds_bgpd   = lvds_q;
  assign timing_load = tl_q;
  assign done        = done_q;

endmodule

// File: rtl/dphy_pwr_seq_chk.sv
module dphy_pwr_seq_chk #(
  parameter int unsigned DATA_LANES = 4,
  parameter int unsigned SETTLE_CYC = 50,
  localparam int unsigned LW = DATA_LANES + 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] lane_ctrl,
  input logic [2:0]    pwr_ctrl,
  input logic          dig_rst_n,
  input logic          lvds_bgpd,
  input logic          timing_load,
  input logic          done
);

  localparam int unsigned BG  = LW - 1;
  localparam int unsigned CLK = LW - 2;
  localparam int unsigned CW  = $clog2(SETTLE_CYC + 2);

  logic [DATA_LANES-1:0] dl;
  assign dl = lane_ctrl[LW-3:2];

  logic [CW-1:0] arst_cnt, drst_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arst_cnt <= '0;
      drst_cnt <= '0;
    end else begin
      arst_cnt <= pwr_ctrl[2] ? arst_cnt + CW'(1) : '0;
      drst_cnt <= !dig_rst_n  ? drst_cnt + CW'(1) : '0;
    end
  end

  assert_arst_after_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ctrl[2]) |-> (lane_ctrl[CLK] && !lane_ctrl[BG] &&
                            lane_ctrl[1:0] == 2'b01 && pwr_ctrl[1:0] == 2'b00));

  assert_pg_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lane_ctrl[1] && lane_ctrl[0]));

  assert_arst_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_ctrl[2]) |-> (arst_cnt == CW'(SETTLE_CYC)));

  assert_drst_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dig_rst_n) |-> (drst_cnt == CW'(SETTLE_CYC)));

  assert_resets_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_ctrl[2] && !dig_rst_n));

  assert_tload_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timing_load |=> !timing_load);

  assert_tload_after_drst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timing_load |-> (dig_rst_n && !pwr_ctrl[2]));

  assert_done_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !lane_ctrl[BG]) |-> (dig_rst_n && !pwr_ctrl[2] && !timing_load));

  assert_therm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dl & (dl + DATA_LANES'(1))) == '0) && ((dl == '0) || lane_ctrl[CLK]));

  assert_dn_lanes_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ctrl[0]) |-> (dl == '0 && !lane_ctrl[CLK]));

  assert_bg_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_ctrl[BG]) |-> (lane_ctrl[1:0] == 2'b10 && pwr_ctrl[1:0] == 2'b11));

  assert_lvds_with_bg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvds_bgpd) |-> lane_ctrl[BG]);

endmodule

bind dphy_pwr_seq dphy_pwr_seq_chk #(
  .DATA_LANES (DATA_LANES),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lane_ctrl   (lane_ctrl),
  .pwr_ctrl    (pwr_ctrl),
  .dig_rst_n   (dig_rst_n),
  .lvds_bgpd   (lvds_bgpd),
  .timing_load (timing_load),
  .done        (done)
);

// File: tb/dphy_pwr_seq_tb.sv
module dphy_pwr_seq_tb;

  localparam int S = (1000 * 4500 + 999_999) / 1_000_000; // R10: 4.5 rounds to 5

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_up_req = 1'b0;
  logic       pwr_dn_req = 1'b0;
  logic [2:0] lane_cnt = 3'd4;
  logic [7:0] lane_ctrl;
  logic [2:0] pwr_ctrl;
  logic       dig_rst_n, lvds_bgpd, timing_load, done;

  int nchk = 0;
  int nfail = 0;

  logic [7:0] m_lane;
  logic [2:0] m_pwr;
  logic       m_lvds;

  always #10 clk = ~clk;

  dphy_pwr_seq #(
    .DATA_LANES   (4),
    .CLK_FREQ_KHZ (4500),
    .SETTLE_NS    (1000)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_up_req  (pwr_up_req),
    .pwr_dn_req  (pwr_dn_req),
    .lane_cnt    (lane_cnt),
    .lane_ctrl   (lane_ctrl),
    .pwr_ctrl    (pwr_ctrl),
    .dig_rst_n   (dig_rst_n),
    .lvds_bgpd   (lvds_bgpd),
    .timing_load (timing_load),
    .done        (done)
  );

  function automatic logic [14:0] obs();
    return {done, timing_load, lvds_bgpd, dig_rst_n, pwr_ctrl, lane_ctrl};
  endfunction

  function automatic logic [3:0] therm(input int n);
    int e;
    e = (n < 1 || n > 4) ? 1 : n;
    return 4'((5'b1 << e) - 5'd1);
  endfunction

  function automatic logic [14:0] up_exp(input int k, input int n);
    logic [7:0] l;
    logic [2:0] p;
    logic drn, tl, dn;
    l = m_lane;
    p = m_pwr;
    if (k >= 1) l[7] = 1'b0;
    if (k >= 2) l[1:0] = 2'b01;
    if (k >= 3) p[1:0] = 2'b00;
    if (k >= 4) l[6:2] = {1'b1, therm(n)};
    p[2] = (k >= 5) && (k <= 4 + S);
    drn  = !((k >= 6 + S) && (k <= 5 + 2 * S));
    tl   = (k == 7 + 2 * S);
    dn   = (k >= 7 + 3 * S);
    return {dn, tl, m_lvds, drn, p, l};
  endfunction

  function automatic logic [14:0] dn_exp(input int k);
    logic [7:0] l;
    logic [2:0] p;
    logic lv, dn;
    l = m_lane;
    p = m_pwr;
    lv = m_lvds;
    dn = 1'b0;
    if (k >= 1) l[6:2] = 5'b0;
    if (k >= 2) p[1:0] = 2'b11;
    if (k >= 3) l[1:0] = 2'b10;
    if (k >= 4) begin l[7] = 1'b1; lv = 1'b1; dn = 1'b1; end
    return {dn, 1'b0, lv, 1'b1, p, l};
  endfunction

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Power-up run; disturb injects requests and lane-count changes mid-run (R9, R7)
  task automatic run_up(input int n, input bit disturb, input bit both);
    string tag;
    int hi;
    hi = 0;
    @(negedge clk);
    pwr_up_req = 1'b1;
    pwr_dn_req = both;
    lane_cnt   = 3'(n);
    @(negedge clk);
    pwr_up_req = 1'b0;
    pwr_dn_req = 1'b0;
    lane_cnt   = 3'($urandom);          // R7: must not affect this run
    for (int k = 0; k <= 8 + 3 * S; k++) begin
      if (both || disturb)          tag = "R9";
      else if (n < 1 || n > 4)      tag = "R6";
      else if (k <= 3)              tag = "R2";
      else if (k == 4)              tag = "R5_R7";
      else if (k <= 6 + 2 * S)      tag = "R3";
      else                          tag = "R4";
      check(tag, obs(), up_exp(k, n));
      if (pwr_ctrl[2]) hi++;
      pwr_up_req = 1'b0;
      pwr_dn_req = 1'b0;
      if (disturb && (k == 2 || k == 6 + S || k == 6 + 3 * S)) begin
        pwr_up_req = 1'b1;
        pwr_dn_req = 1'b1;
        lane_cnt   = 3'($urandom);
      end
      @(negedge clk);
    end
    pwr_up_req = 1'b0;
    pwr_dn_req = 1'b0;
    check("R10", 15'(hi), 15'(S));
    m_lane = {2'b01, therm(n), 2'b01};
    m_pwr  = 3'b000;
  endtask

  task automatic run_dn(input bit disturb);
    @(negedge clk);
    pwr_dn_req = 1'b1;
    @(negedge clk);
    pwr_dn_req = 1'b0;
    for (int k = 0; k <= 5; k++) begin
      check(disturb ? "R9" : "R8", obs(), dn_exp(k));
      pwr_up_req = disturb && (k == 1 || k == 3);
      @(negedge clk);
    end
    pwr_up_req = 1'b0;
    m_lane = 8'h82;
    m_pwr  = 3'b011;
    m_lvds = 1'b1;
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_lane = 8'h82;
    m_pwr  = 3'b011;
    m_lvds = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", obs(), {1'b0, 1'b0, 1'b0, 1'b1, 3'b011, 8'h82});
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", obs(), {1'b0, 1'b0, 1'b0, 1'b1, 3'b011, 8'h82});

    run_up(4, 1'b0, 1'b0);
    run_dn(1'b0);
    run_up(1, 1'b0, 1'b0);
    run_up(2, 1'b0, 1'b0);
    run_up(3, 1'b0, 1'b0);
    run_up(4, 1'b0, 1'b0);
    run_up(2, 1'b0, 1'b0);              // R5: upper lanes cleared again
    run_up(0, 1'b0, 1'b0);              // R6
    run_up(5, 1'b0, 1'b0);              // R6
    run_up(7, 1'b0, 1'b0);              // R6
    run_dn(1'b1);                       // R9
    run_up(3, 1'b0, 1'b1);              // R9: up wins over simultaneous down
    run_up(4, 1'b1, 1'b0);              // R9
    run_dn(1'b0);
    run_dn(1'b0);                       // R8 from already-off state

    for (int it = 0; it < 24; it++) begin
      if ($urandom % 2 == 0) run_up(int'($urandom % 8), bit'($urandom % 2), bit'($urandom % 2));
      else                   run_dn(bit'($urandom % 2));
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule